// File: doc/BRIEF.md
# Store-Aware Forwarding and Load-Use Stall Unit

This combinational unit sits beside a five-stage in-order integer pipeline. Each cycle it reads the register numbers and control bits held in the ID/EX, EX/MEM and MEM/WB pipeline registers, together with the source fields of the instruction being decoded. From these it produces the forwarding selects for both ALU operands and two extra store-data forwarding flags. One flag serves a store in the EX stage. The other serves a store in the MEM stage.

A load's result only exists once the load has passed the memory stage. An instruction that uses that result as its address base, or as an ALU operand, one cycle later must therefore wait one cycle. The unit detects this case in decode. It then freezes the program counter and the IF/ID register and injects an all-zero control bubble into ID/EX. After the bubble, the ordinary MEM/WB forwarding path delivers the value.

A store that needs the loaded value only as its write data does not stall. That value is handed over late, through the MEM-stage store-data forward.

Top module: `store_fwd_hazard_unit`

## Requirements
- R1: `fwdA` is 2'b10 (take EX/MEM) when EX/MEM writes a register, its destination is nonzero and equals `idExRs`.
- R2: `fwdA` is 2'b01 (take MEM/WB) when MEM/WB writes a nonzero destination equal to `idExRs` and the EX/MEM condition of R1 does not hold. When both stages match, EX/MEM wins and the select is 2'b10.
- R3: A destination register of 0 is never forwarded. The select stays 2'b00 (register file) even when the write enable is set and the register numbers match.
- R4: With neither later stage writing a register, both operand selects are 2'b00, whatever the register numbers are.
- R5: `fwdB` follows the same rules as R1 to R3, applied to `idExRt`. This covers an R-type result used as store data by the next store.
- R6: `fwdStoreMem` is 1 exactly when MEM/WB writes a register, EX/MEM is a memory write, the MEM/WB destination equals `exMemRt`, and that destination is nonzero.
- R7: `fwdStoreEx` is 1 exactly when ID/EX is a memory write, MEM/WB writes a register, the MEM/WB destination equals `idExRt`, and that destination is nonzero.
- R8: When ID/EX holds a load (`idExMemRead`=1) whose nonzero destination `idExRd` equals `idRs` (the base/first source of the decoding instruction), the unit stalls. A stall means `pcWrite`=0, `ifIdWrite`=0 and `idExBubble`=1.
- R9: A load destination equal to `idRt` stalls only when `idRtIsAluSrc`=1. A store whose data register matches, with `idRtIsAluSrc`=0, does not stall.
- R10: No stall occurs when the ID/EX instruction is not a load, or when the load's destination is register 0.
- R11: Whenever no stall is raised, `pcWrite`=1, `ifIdWrite`=1 and `idExBubble`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs | input | REG_W | First source register of the instruction in ID |
| idRt | input | REG_W | Second source register of the instruction in ID |
| idRtIsAluSrc | input | 1 | Instruction in ID reads rt as an ALU operand |
| idExMemRead | input | 1 | ID/EX instruction is a load |
| idExMemWrite | input | 1 | ID/EX instruction is a store |
| idExRd | input | REG_W | Destination register of the ID/EX instruction |
| idExRs | input | REG_W | rs field held in ID/EX |
| idExRt | input | REG_W | rt field held in ID/EX |
| exMemRegWrite | input | 1 | EX/MEM instruction writes a register |
| exMemMemWrite | input | 1 | EX/MEM instruction is a store |
| exMemRd | input | REG_W | Destination register in EX/MEM |
| exMemRt | input | REG_W | Store data register held in EX/MEM |
| memWbRegWrite | input | 1 | MEM/WB instruction writes a register |
| memWbRd | input | REG_W | Destination register in MEM/WB |
| fwdA | output | 2 | Operand A select: 00 regfile, 10 EX/MEM, 01 MEM/WB |
| fwdB | output | 2 | Operand B select, same encoding |
| fwdStoreEx | output | 1 | Store in EX takes its data from MEM/WB |
| fwdStoreMem | output | 1 | Store in MEM takes its data from MEM/WB |
| pcWrite | output | 1 | Program counter update enable |
| ifIdWrite | output | 1 | IF/ID register update enable |
| idExBubble | output | 1 | Zero all control bits loaded into ID/EX |

## Verification
The checks assume that the control bits arrive decoded consistently. A load sets `idExMemRead` and names its destination in `idExRd`. A store never has its register-write bit set in the same stage. Only `idRtIsAluSrc` says whether rt feeds the ALU. The directed tasks only drive legal combinations of this kind, such as a load with memory write clear or a store with register write clear. Each scenario is applied and allowed to settle before the outputs are sampled, so the combinational checks never see a half-updated input set.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MEMWB = 2'b01,
    FWD_EXMEM = 2'b10
  } fwdSel_e;

  // strobes from the stall controller to the datapath side
  typedef struct packed {
    logic holdFront;
    logic insertBubble;
  } hzdStrobe_t;

endpackage

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic             idRtIsAluSrc,
  input  logic             idExMemRead,
  input  logic [REG_W-1:0] idExRd,
  output hzdStrobe_t       strobe
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic loadLive;
  logic baseHit;
  logic rtHit;
  logic needStall;

  always_comb begin
    loadLive  = idExMemRead && (idExRd != ZERO_REG);
    baseHit   = (idExRd == idRs);
    rtHit     = idRtIsAluSrc && (idExRd == idRt);
    needStall = loadLive && (baseHit || rtHit);
    strobe.holdFront    = needStall;
    strobe.insertBubble = needStall;
  end

endmodule

// File: rtl/hzd_fwd_path.sv
module hzd_fwd_path
  import hzd_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_OPS = 2
) (
  input  hzdStrobe_t       strobe,
  input  logic [REG_W-1:0] opReg [NUM_OPS],
  input  logic             idExMemWrite,
  input  logic [REG_W-1:0] idExRt,
  input  logic             exMemRegWrite,
  input  logic             exMemMemWrite,
  input  logic [REG_W-1:0] exMemRd,
  input  logic [REG_W-1:0] exMemRt,
  input  logic             memWbRegWrite,
  input  logic [REG_W-1:0] memWbRd,
  output fwdSel_e          opSel [NUM_OPS],
  output logic             fwdStoreEx,
  output logic             fwdStoreMem,
  output logic             pcWrite,
  output logic             ifIdWrite,
  output logic             idExBubble
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic exMemLive;
  logic memWbLive;

  assign exMemLive = exMemRegWrite && (exMemRd != ZERO_REG);
  assign memWbLive = memWbRegWrite && (memWbRd != ZERO_REG);

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    always_comb begin
      if (exMemLive && (exMemRd == opReg[g]))
        opSel[g] = FWD_EXMEM;
      else if (memWbLive && (memWbRd == opReg[g]))
        opSel[g] = FWD_MEMWB;
      else
        opSel[g] = FWD_RF;
    end
  end

  always_comb begin
    fwdStoreEx  = idExMemWrite && memWbLive && (memWbRd == idExRt);
    fwdStoreMem = exMemMemWrite && memWbLive && (memWbRd == exMemRt);
    pcWrite     = !strobe.holdFront;
    ifIdWrite   = !strobe.holdFront;
    idExBubble  = strobe.insertBubble;
  end

endmodule

// File: rtl/store_fwd_hazard_unit.sv
module store_fwd_hazard_unit
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic             idRtIsAluSrc,
  input  logic             idExMemRead,
  input  logic             idExMemWrite,
  input  logic [REG_W-1:0] idExRd,
  input  logic [REG_W-1:0] idExRs,
  input  logic [REG_W-1:0] idExRt,
  input  logic             exMemRegWrite,
  input  logic             exMemMemWrite,
  input  logic [REG_W-1:0] exMemRd,
  input  logic [REG_W-1:0] exMemRt,
  input  logic             memWbRegWrite,
  input  logic [REG_W-1:0] memWbRd,
  output logic [1:0]       fwdA,
  output logic [1:0]       fwdB,
  output logic             fwdStoreEx,
  output logic             fwdStoreMem,
  output logic             pcWrite,
  output logic             ifIdWrite,
  output logic             idExBubble
);

  localparam int NUM_OPS = 2;

  hzdStrobe_t       strobe;
  logic [REG_W-1:0] opReg [NUM_OPS];
  fwdSel_e          opSel [NUM_OPS];

  assign opReg[0] = idExRs;
  assign opReg[1] = idExRt;
  assign fwdA     = opSel[0];
  assign fwdB     = opSel[1];

  hzd_stall_ctrl #(.REG_W(REG_W)) u_ctrl (
    .idRs         (idRs),
    .idRt         (idRt),
    .idRtIsAluSrc (idRtIsAluSrc),
    .idExMemRead  (idExMemRead),
    .idExRd       (idExRd),
    .strobe       (strobe)
  );

  hzd_fwd_path #(.REG_W(REG_W), .NUM_OPS(NUM_OPS)) u_path (
    .strobe        (strobe),
    .opReg         (opReg),
    .idExMemWrite  (idExMemWrite),
    .idExRt        (idExRt),
    .exMemRegWrite (exMemRegWrite),
    .exMemMemWrite (exMemMemWrite),
    .exMemRd       (exMemRd),
    .exMemRt       (exMemRt),
    .memWbRegWrite (memWbRegWrite),
    .memWbRd       (memWbRd),
    .opSel         (opSel),
    .fwdStoreEx    (fwdStoreEx),
    .fwdStoreMem   (fwdStoreMem),
    .pcWrite       (pcWrite),
    .ifIdWrite     (ifIdWrite),
    .idExBubble    (idExBubble)
  );

endmodule

// File: rtl/store_fwd_hazard_chk.sv
module store_fwd_hazard_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] idExRs,
  input logic             idExMemRead,
  input logic [REG_W-1:0] idExRd,
  input logic             exMemRegWrite,
  input logic             exMemMemWrite,
  input logic [REG_W-1:0] exMemRd,
  input logic             memWbRegWrite,
  input logic [REG_W-1:0] memWbRd,
  input logic [1:0]       fwdA,
  input logic [1:0]       fwdB,
  input logic             fwdStoreMem,
  input logic             pcWrite,
  input logic             ifIdWrite,
  input logic             idExBubble
);

  always_comb begin
    AST_BUBBLE_FREEZES: assert (!idExBubble || (!pcWrite && !ifIdWrite)); // R8
    AST_IDLE_ADVANCES: assert (idExBubble || (pcWrite && ifIdWrite)); // R11
    AST_STALL_NEEDS_LOAD: assert (!idExBubble || (idExMemRead && idExRd != '0)); // R10
    AST_SEL_A_LEGAL: assert (fwdA != 2'b11); // R1
    AST_SEL_B_LEGAL: assert (fwdB != 2'b11); // R5
    AST_ZERO_NOT_FWD: assert (fwdA != 2'b01 || memWbRd != '0); // R3
    AST_EXMEM_WINS: assert (fwdA != 2'b01 || !(exMemRegWrite && exMemRd != '0 && exMemRd == idExRs)); // R2
    AST_NO_WRITE_NO_FWD: assert (exMemRegWrite || memWbRegWrite || (fwdA == 2'b00 && fwdB == 2'b00)); // R4
    AST_STORE_MEM_SRC: assert (!fwdStoreMem || (exMemMemWrite && memWbRegWrite)); // R6
  end

endmodule

bind store_fwd_hazard_unit store_fwd_hazard_chk #(.REG_W(REG_W)) u_chk (
  .idExRs        (idExRs),
  .idExMemRead   (idExMemRead),
  .idExRd        (idExRd),
  .exMemRegWrite (exMemRegWrite),
  .exMemMemWrite (exMemMemWrite),
  .exMemRd       (exMemRd),
  .memWbRegWrite (memWbRegWrite),
  .memWbRd       (memWbRd),
  .fwdA          (fwdA),
  .fwdB          (fwdB),
  .fwdStoreMem   (fwdStoreMem),
  .pcWrite       (pcWrite),
  .ifIdWrite     (ifIdWrite),
  .idExBubble    (idExBubble)
);

// File: tb/store_fwd_hazard_unit_tb.sv
module store_fwd_hazard_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  int   nChecks = 0;
  int   nFails = 0;
  logic finished = 1'b0;

  logic [REG_W-1:0] idRs, idRt, idExRd, idExRs, idExRt, exMemRd, exMemRt, memWbRd;
  logic idRtIsAluSrc, idExMemRead, idExMemWrite, exMemRegWrite, exMemMemWrite, memWbRegWrite;
  logic [1:0] fwdA, fwdB;
  logic fwdStoreEx, fwdStoreMem, pcWrite, ifIdWrite, idExBubble;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_fwd_hazard_unit #(.REG_W(REG_W)) u_dut (
    .idRs(idRs), .idRt(idRt), .idRtIsAluSrc(idRtIsAluSrc),
    .idExMemRead(idExMemRead), .idExMemWrite(idExMemWrite),
    .idExRd(idExRd), .idExRs(idExRs), .idExRt(idExRt),
    .exMemRegWrite(exMemRegWrite), .exMemMemWrite(exMemMemWrite),
    .exMemRd(exMemRd), .exMemRt(exMemRt),
    .memWbRegWrite(memWbRegWrite), .memWbRd(memWbRd),
    .fwdA(fwdA), .fwdB(fwdB), .fwdStoreEx(fwdStoreEx), .fwdStoreMem(fwdStoreMem),
    .pcWrite(pcWrite), .ifIdWrite(ifIdWrite), .idExBubble(idExBubble)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clearAll();
    @(negedge clk);
    idRs = 5'd0; idRt = 5'd0; idRtIsAluSrc = 1'b0;
    idExMemRead = 1'b0; idExMemWrite = 1'b0;
    idExRd = 5'd0; idExRs = 5'd0; idExRt = 5'd0;
    exMemRegWrite = 1'b0; exMemMemWrite = 1'b0; exMemRd = 5'd0; exMemRt = 5'd0;
    memWbRegWrite = 1'b0; memWbRd = 5'd0;
  endtask

  task automatic settle();
    #(CLK_PERIOD/4);
  endtask

  // front-end status packed as {pcWrite, ifIdWrite, idExBubble}
  function automatic logic [3:0] front();
    return {1'b0, pcWrite, ifIdWrite, idExBubble};
  endfunction

  task automatic tIdle();
    clearAll();
    idExRs = 5'd3; idExRt = 5'd4; exMemRd = 5'd3; memWbRd = 5'd4;
    settle();
    check("R4 fwdA idle", {2'b0, fwdA}, 4'b0000);
    check("R4 fwdB idle", {2'b0, fwdB}, 4'b0000);
    check("R11 front idle", front(), 4'b0110);
  endtask

  task automatic tExMemFwd();
    clearAll();
    idExRs = 5'd7; idExRt = 5'd9; exMemRegWrite = 1'b1; exMemRd = 5'd7;
    settle();
    check("R1 fwdA exmem", {2'b0, fwdA}, 4'b0010);
    check("R5 fwdB no match", {2'b0, fwdB}, 4'b0000);
  endtask

  task automatic tMemWbAndPriority();
    clearAll();
    idExRs = 5'd6; idExRt = 5'd6; memWbRegWrite = 1'b1; memWbRd = 5'd6;
    settle();
    check("R2 fwdA memwb", {2'b0, fwdA}, 4'b0001);
    check("R5 fwdB memwb", {2'b0, fwdB}, 4'b0001);
    exMemRegWrite = 1'b1; exMemRd = 5'd6;
    settle();
    check("R2 fwdA priority", {2'b0, fwdA}, 4'b0010);
    check("R5 fwdB priority", {2'b0, fwdB}, 4'b0010);
  endtask

  task automatic tZeroReg();
    clearAll();
    exMemRegWrite = 1'b1; memWbRegWrite = 1'b1; idExMemWrite = 1'b1; exMemMemWrite = 1'b1;
    settle();
    check("R3 fwdA r0", {2'b0, fwdA}, 4'b0000);
    check("R3 fwdB r0", {2'b0, fwdB}, 4'b0000);
    check("R3 store flags r0", {2'b0, fwdStoreEx, fwdStoreMem}, 4'b0000);
    // EX/MEM writes r0 but MEM/WB has a real match: must fall through
    idExRs = 5'd0; memWbRd = 5'd0;
    idExRt = 5'd12; memWbRd = 5'd12;
    settle();
    check("R3 fwdB skip r0 exmem", {2'b0, fwdB}, 4'b0001);
  endtask

  task automatic tRtypeThenStore();
    clearAll();
    // R-type wrote r8 is in EX/MEM, store sw r8,0(r8) in EX
    idExMemWrite = 1'b1; idExRs = 5'd8; idExRt = 5'd8;
    exMemRegWrite = 1'b1; exMemRd = 5'd8;
    settle();
    check("R5 store data exmem", {2'b0, fwdB}, 4'b0010);
    check("R1 store base exmem", {2'b0, fwdA}, 4'b0010);
    check("R7 no memwb store fwd", {3'b0, fwdStoreEx}, 4'b0000);
  endtask

  task automatic tStoreEx();
    clearAll();
    idExMemWrite = 1'b1; idExRt = 5'd5; memWbRegWrite = 1'b1; memWbRd = 5'd5;
    settle();
    check("R7 store ex fwd", {3'b0, fwdStoreEx}, 4'b0001);
    idExMemWrite = 1'b0;
    settle();
    check("R7 not a store", {3'b0, fwdStoreEx}, 4'b0000);
    idExMemWrite = 1'b1; memWbRegWrite = 1'b0;
    settle();
    check("R7 no regwrite", {3'b0, fwdStoreEx}, 4'b0000);
  endtask

  task automatic tStoreMem();
    clearAll();
    exMemMemWrite = 1'b1; exMemRt = 5'd15; memWbRegWrite = 1'b1; memWbRd = 5'd15;
    settle();
    check("R6 store mem fwd", {3'b0, fwdStoreMem}, 4'b0001);
    exMemRt = 5'd14;
    settle();
    check("R6 reg mismatch", {3'b0, fwdStoreMem}, 4'b0000);
    exMemRt = 5'd15; exMemMemWrite = 1'b0;
    settle();
    check("R6 not a store", {3'b0, fwdStoreMem}, 4'b0000);
  endtask

  task automatic tLoadUseBase();
    clearAll();
    idExMemRead = 1'b1; idExRd = 5'd15; idRs = 5'd15; idRt = 5'd5;
    settle();
    check("R8 base stall", front(), 4'b0001);
  endtask

  task automatic tLoadUseRt();
    clearAll();
    idExMemRead = 1'b1; idExRd = 5'd2; idRs = 5'd9; idRt = 5'd2; idRtIsAluSrc = 1'b1;
    settle();
    check("R9 alu rt stall", front(), 4'b0001);
    idRtIsAluSrc = 1'b0;
    settle();
    check("R9 store data no stall", front(), 4'b0110);
  endtask

  task automatic tNoStall();
    clearAll();
    idExRd = 5'd4; idRs = 5'd4; idRtIsAluSrc = 1'b1; idRt = 5'd4;
    settle();
    check("R10 not a load", front(), 4'b0110);
    idExMemRead = 1'b1; idExRd = 5'd0; idRs = 5'd0; idRt = 5'd0;
    settle();
    check("R10 load to r0", front(), 4'b0110);
    idExRd = 5'd3; idRs = 5'd1; idRt = 5'd2;
    settle();
    check("R11 load no match", front(), 4'b0110);
  endtask

  initial begin
    clearAll();
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    tIdle();
    tExMemFwd();
    tMemWbAndPriority();
    tZeroReg();
    tRtypeThenStore();
    tStoreEx();
    tStoreMem();
    tLoadUseBase();
    tLoadUseRt();
    tNoStall();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule